// File: doc/BRIEF.md
# Word-Count DMA Interface Controller

This block is a single-channel DMA engine that moves 16-bit words between system memory and an external parallel device port. Software sees four 16-bit registers chosen by a 2-bit select: a word counter, a low address, a control/status word and a data word. To start a transfer it loads the counter with the two's-complement negative of the number of words and loads the start address. It then writes the control word with the start bit set. The start bit acts as a one-cycle command and is never stored. A control write without it only sets the mode.

While a transfer runs, the engine holds a request on a simple request/grant memory bus. Each grant moves one word. In the device-to-memory direction the word on `dev_in` is written to memory. In the other direction the memory word is latched and shown on `dev_out` with a one-cycle strobe. After each word the counter steps up by one and the address steps by two. The carry out of the low address reaches two extension bits kept in the control word, which gives an 18-bit byte address. The transfer ends when the counter reaches zero, when a memory error is reported, or when software writes the attention and wakeup bits together. The remaining count stays readable, and the residual byte count is the negated count times two.

Top module: `wc_dma_ctrl`

## Requirements
- R1: After reset every register reads 0, `mem_req` is low and `irq` is low.
- R2: A control write (select 2) while idle with bit 0 clear loads the mode fields: bit 1 direction, bits 5:4 address bits 17:16, bit 6 interrupt enable. These read back at the same positions, and no memory request follows.
- R3: A control write while idle with bit 0 set, when the counter (select 0) holds -N with N>0, makes exactly N granted word moves. The counter then reads 0, `mem_req` drops and the done flag (control bit 7) is set.
- R4: The 18-bit memory address steps by 2 per moved word. The low 16 bits read at select 1 and the upper 2 bits read at control bits 5:4. A carry out of bit 15 increments bits 17:16.
- R5: With direction 1 each word on `dev_in` is written to memory with `mem_we` high. With direction 0 `mem_we` is low, and the granted `mem_rdata` word appears on `dev_out` (also at select 3) with `dev_stb` high for one cycle after the grant.
- R6: `irq` is high exactly when the interrupt enable is set and either done or the attention flag (control bit 13) is set.
- R7: A control write with bits 13 and 3 both set during a transfer ends it. `mem_req` is low from the next cycle, the counter keeps the partial value, and done and attention are both set.
- R8: When the ending write of R7 falls in the same cycle as a grant, that word is still moved and counted.
- R9: A grant that comes with `mem_err` high moves no word and ends the transfer with the error flag (control bit 15) and done set. The counter does not advance.
- R10: A control write of 0 while idle clears done, attention and error, and drops `irq`.
- R11: A start with the counter at 0 sets done on the next cycle and issues no memory request.
- R12: While a transfer runs, writes to the counter, the address, and control writes without both bits 13 and 3, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select: 0 count, 1 address, 2 control, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mem_req | output | 1 | Memory word request, high during a transfer |
| mem_we | output | 1 | Memory write (device-to-memory direction) |
| mem_addr | output | 18 | Memory byte address |
| mem_wdata | output | 16 | Word written to memory |
| mem_rdata | input | 16 | Word read from memory |
| mem_gnt | input | 1 | Grant: one word moves in this cycle |
| mem_err | input | 1 | Bus error, qualified by grant |
| dev_in | input | 16 | Device word toward memory |
| dev_out | output | 16 | Last word moved |
| dev_stb | output | 1 | One-cycle strobe for a word sent to the device |
| irq | output | 1 | Interrupt request |

## Verification
A software abort and a memory grant can land on the same clock edge. The outcome in that case is that the word is moved and counted, and then the transfer stops. The bench provokes this by starting a four-word transfer with grants always on and writing the abort on the second grant edge. It then judges the case by the counter reading -2 rather than -3 or -1, the address advanced by four, and both done and attention set.

// File: rtl/wc_dma_pkg.sv
package wc_dma_pkg;
  // Register select codes
  localparam logic [1:0] SEL_COUNT = 2'd0;
  localparam logic [1:0] SEL_ADDR  = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;
  localparam logic [1:0] SEL_DATA  = 2'd3;

  // Control/status bit positions (software decodes these)
  localparam int unsigned B_START  = 0;
  localparam int unsigned B_TOMEM  = 1;
  localparam int unsigned B_WAKE   = 3;
  localparam int unsigned B_EXT_LO = 4;
  localparam int unsigned B_IE     = 6;
  localparam int unsigned B_DONE   = 7;
  localparam int unsigned B_ALERT  = 13;
  localparam int unsigned B_FAULT  = 15;
endpackage

// File: rtl/wc_dma_counters.sv
module wc_dma_counters #(
  parameter int unsigned W  = 16,
  parameter int unsigned XW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_cnt,
  input  logic            load_addr,
  input  logic            load_ext,
  input  logic [W-1:0]    wdata,
  input  logic [XW-1:0]   ext_in,
  input  logic            step,
  output logic [W-1:0]    cnt_q,
  output logic [W+XW-1:0] addr_q,
  output logic            cnt_zero,
  output logic            cnt_last
);
  localparam int unsigned AW = W + XW;
  localparam logic [W-1:0]  CNT_INC  = W'(1);
  localparam logic [AW-1:0] ADDR_INC = AW'(2);

  function automatic logic [W-1:0] count_up(input logic [W-1:0] c);
    return c + CNT_INC;
  endfunction

  function automatic logic [AW-1:0] addr_step(input logic [AW-1:0] a);
    return a + ADDR_INC;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (step) begin
      cnt_q  <= count_up(cnt_q);
      addr_q <= addr_step(addr_q);
    end else begin
      if (load_cnt)  cnt_q          <= wdata;
      if (load_addr) addr_q[W-1:0]  <= wdata;
      if (load_ext)  addr_q[AW-1:W] <= ext_in;
    end
  end

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == '1);

  assert_last_reaches_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_last) |=> cnt_zero);
  assert_addr_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && addr_q[W-1:1] == '1) |=>
      (addr_q[W-1:1] == '0 && addr_q[AW-1:W] == $past(addr_q[AW-1:W]) + XW'(1)));
  assert_count_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load_cnt) |=> $stable(cnt_q));
endmodule

// File: rtl/wc_dma_seq.sv
module wc_dma_seq #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic [W-1:0] ctl_data,
  input  logic         gnt,
  input  logic         err,
  input  logic         cnt_zero,
  input  logic         cnt_last,
  output logic         busy,
  output logic         done,
  output logic         alert,
  output logic         fault,
  output logic         to_mem,
  output logic         irq_en,
  output logic         step,
  output logic         idle_ctl_wr
);
  import wc_dma_pkg::*;

  logic abort_hit, fault_evt, last_ok, go_hit, clr_hit;

  assign idle_ctl_wr = ctl_wr && !busy;
  assign abort_hit   = ctl_wr && busy && ctl_data[B_ALERT] && ctl_data[B_WAKE];
  assign step        = busy && gnt && !err;
  assign fault_evt   = busy && gnt && err;
  assign last_ok     = step && cnt_last;
  assign go_hit      = idle_ctl_wr && ctl_data[B_START];
  assign clr_hit     = idle_ctl_wr && (ctl_data[B_START] || ctl_data == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      alert  <= 1'b0;
      fault  <= 1'b0;
      to_mem <= 1'b0;
      irq_en <= 1'b0;
    end else begin
      if (abort_hit || fault_evt || last_ok) busy <= 1'b0;
      else if (go_hit && !cnt_zero)          busy <= 1'b1;

      if (clr_hit)                                  done <= go_hit && cnt_zero;
      else if (abort_hit || fault_evt || last_ok)   done <= 1'b1;

      if (clr_hit)        alert <= 1'b0;
      else if (abort_hit) alert <= 1'b1;

      if (clr_hit)        fault <= 1'b0;
      else if (fault_evt) fault <= 1'b1;

      if (idle_ctl_wr) begin
        to_mem <= ctl_data[B_TOMEM];
        irq_en <= ctl_data[B_IE];
      end
    end
  end

  assert_abort_stops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort_hit |=> (!busy && done && alert));
  assert_fault_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (!busy && done && fault));
  assert_empty_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (go_hit && cnt_zero) |=> (done && !busy));
  assert_mode_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> ($stable(to_mem) && $stable(irq_en)));
endmodule

// File: rtl/wc_dma_ctrl.sv
module wc_dma_ctrl #(
  parameter int unsigned W  = 16,
  parameter int unsigned XW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      reg_sel,
  input  logic            reg_wr,
  input  logic [W-1:0]    reg_wdata,
  output logic [W-1:0]    reg_rdata,
  output logic            mem_req,
  output logic            mem_we,
  output logic [W+XW-1:0] mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  input  logic            mem_gnt,
  input  logic            mem_err,
  input  logic [W-1:0]    dev_in,
  output logic [W-1:0]    dev_out,
  output logic            dev_stb,
  output logic            irq
);
  import wc_dma_pkg::*;

  localparam int unsigned AW = W + XW;

  logic          busy, done, alert, fault, to_mem, irq_en, step, idle_ctl_wr;
  logic          cnt_zero, cnt_last, ctl_wr;
  logic [W-1:0]  cnt_q, data_q, csr;
  logic [AW-1:0] addr_q;

  assign ctl_wr = reg_wr && (reg_sel == SEL_CTRL);

  wc_dma_seq #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_data(reg_wdata),
    .gnt(mem_gnt), .err(mem_err), .cnt_zero(cnt_zero), .cnt_last(cnt_last),
    .busy(busy), .done(done), .alert(alert), .fault(fault),
    .to_mem(to_mem), .irq_en(irq_en), .step(step), .idle_ctl_wr(idle_ctl_wr)
  );

  wc_dma_counters #(.W(W), .XW(XW)) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .load_cnt(reg_wr && !busy && reg_sel == SEL_COUNT),
    .load_addr(reg_wr && !busy && reg_sel == SEL_ADDR),
    .load_ext(idle_ctl_wr),
    .wdata(reg_wdata), .ext_in(reg_wdata[B_EXT_LO +: XW]), .step(step),
    .cnt_q(cnt_q), .addr_q(addr_q), .cnt_zero(cnt_zero), .cnt_last(cnt_last)
  );

  // Data word and device strobe
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      dev_stb <= 1'b0;
    end else begin
      dev_stb <= step && !to_mem;
      if (step) data_q <= to_mem ? dev_in : mem_rdata;
    end
  end

  always_comb begin
    csr = '0;
    csr[B_TOMEM]           = to_mem;
    csr[B_EXT_LO +: XW]    = addr_q[AW-1:W];
    csr[B_IE]              = irq_en;
    csr[B_DONE]            = done;
    csr[B_ALERT]           = alert;
    csr[B_FAULT]           = fault;
  end

  always_comb begin
    case (reg_sel)
      SEL_COUNT: reg_rdata = cnt_q;
      SEL_ADDR:  reg_rdata = addr_q[W-1:0];
      SEL_CTRL:  reg_rdata = csr;
      default:   reg_rdata = data_q;
    endcase
  end

  assign mem_req   = busy;
  assign mem_we    = busy && to_mem;
  assign mem_addr  = addr_q;
  assign mem_wdata = dev_in;
  assign dev_out   = data_q;
  assign irq       = irq_en && (done || alert);

  assert_dev_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !to_mem) |=> (dev_stb && dev_out == $past(mem_rdata)));
  assert_irq_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && irq_en && !ctl_wr && !mem_gnt) |=> (!irq || !mem_req));
  assert_req_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_last) |=> !mem_req);
endmodule

// File: tb/tb_wc_dma_ctrl.sv
module tb_wc_dma_ctrl;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [17:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        mem_gnt = 1'b0;
  logic        mem_err = 1'b0;
  logic [15:0] dev_in = 16'h0;
  logic [15:0] dev_out;
  logic        dev_stb, irq;

  int checks = 0;
  int failures = 0;
  bit gnt_en = 1'b0;
  int word_idx = 0;
  int stb_cnt = 0;
  logic [15:0] last_out = 16'h0;
  logic [15:0] mem [0:255];
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wc_dma_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .dev_in(dev_in), .dev_out(dev_out), .dev_stb(dev_stb), .irq(irq)
  );

  // Memory and device models
  assign mem_rdata = mem[mem_addr[8:1]];
  always @(posedge clk) begin
    if (mem_req && mem_gnt) begin
      word_idx <= word_idx + 1;
      if (mem_we && !mem_err) mem[mem_addr[8:1]] <= mem_wdata;
    end
    if (dev_stb) begin
      stb_cnt  <= stb_cnt + 1;
      last_out <= dev_out;
    end
  end
  always @(negedge clk) begin
    mem_gnt = mem_req && gnt_en;
    dev_in  = 16'hA000 + 16'(word_idx);
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    reg_sel = s; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      @(negedge clk);
      reg_sel = 2'd2;
      #1 seen = reg_rdata[7];
    end
    if (!seen) check({tag, " done timeout"}, 0, 1);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(2'd0, v); check("R1 count", v, 0);
    rd(2'd1, v); check("R1 addr", v, 0);
    rd(2'd2, v); check("R1 ctrl", v, 0);
    check("R1 req", mem_req, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_mode();
    logic [15:0] v;
    wr(2'd2, 16'h0062);
    rd(2'd2, v); check("R2 mode readback", v, 16'h0062);
    repeat (3) @(negedge clk);
    check("R2 no request", mem_req, 0);
    wr(2'd2, 16'h0000);
  endtask

  task automatic t_to_mem();
    logic [15:0] v;
    int base;
    gnt_en = 1'b1;
    wr(2'd0, 16'hFFFD);
    wr(2'd1, 16'h0010);
    base = word_idx;
    wr(2'd2, 16'h0003);
    wait_done("R3");
    @(negedge clk);
    check("R5 word0 to memory", mem[8],  16'hA000 + 16'(base));
    check("R5 word1 to memory", mem[9],  16'hA000 + 16'(base + 1));
    check("R5 word2 to memory", mem[10], 16'hA000 + 16'(base + 2));
    check("R3 moves", word_idx - base, 3);
    rd(2'd0, v); check("R3 count zero", v, 0);
    rd(2'd1, v); check("R4 end address", v, 16'h0016);
    rd(2'd2, v); check("R3 ctrl done", v, 16'h0082);
    check("R3 req low", mem_req, 0);
    check("R6 irq off without enable", irq, 0);
  endtask

  task automatic t_from_mem();
    logic [15:0] v;
    int s0;
    wr(2'd2, 16'h0000);
    mem[32] = 16'h1111; mem[33] = 16'h2222;
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'h0040);
    s0 = stb_cnt;
    wr(2'd2, 16'h0041);
    wait_done("R5");
    repeat (2) @(negedge clk);
    check("R5 strobes", stb_cnt - s0, 2);
    check("R5 last device word", last_out, 16'h2222);
    rd(2'd3, v); check("R5 data register", v, 16'h2222);
    rd(2'd2, v); check("R5 ctrl", v, 16'h00C0);
    check("R6 irq on done", irq, 1);
  endtask

  task automatic t_clear();
    logic [15:0] v;
    wr(2'd2, 16'h0000);
    rd(2'd2, v); check("R10 cleared", v, 0);
    check("R10 irq dropped", irq, 0);
  endtask

  task automatic t_carry();
    logic [15:0] v;
    int base;
    wr(2'd0, 16'hFFFE);
    wr(2'd1, 16'hFFFE);
    base = word_idx;
    wr(2'd2, 16'h0003);
    wait_done("R4");
    @(negedge clk);
    check("R4 word below carry", mem[255], 16'hA000 + 16'(base));
    check("R4 word above carry", mem[0],   16'hA000 + 16'(base + 1));
    rd(2'd1, v); check("R4 low address", v, 16'h0002);
    rd(2'd2, v); check("R4 extension bits", v, 16'h0092);
  endtask

  task automatic t_empty();
    logic [15:0] v;
    int base;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0000);
    base = word_idx;
    wr(2'd2, 16'h0001);
    check("R11 no request", mem_req, 0);
    rd(2'd2, v); check("R11 done at once", v, 16'h0080);
    check("R11 no moves", word_idx - base, 0);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    wr(2'd2, 16'h0000);
    gnt_en = 1'b0;
    wr(2'd0, 16'hFFFD);
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'h0043);
    @(negedge clk);
    check("R7 running", mem_req, 1);
    wr(2'd0, 16'h1234);
    wr(2'd1, 16'h5555);
    wr(2'd2, 16'h0000);
    rd(2'd0, v); check("R12 count held", v, 16'hFFFD);
    rd(2'd1, v); check("R12 address held", v, 16'h0100);
    rd(2'd2, v); check("R12 ctrl held", v, 16'h0042);
    check("R12 still running", mem_req, 1);
    wr(2'd2, 16'h2048);
    check("R7 request dropped", mem_req, 0);
    rd(2'd0, v); check("R7 partial count", v, 16'hFFFD);
    rd(2'd2, v); check("R7 done and attention", v, 16'h20C2);
    check("R6 irq on attention", irq, 1);
    gnt_en = 1'b1;
  endtask

  task automatic t_abort_grant();
    logic [15:0] v;
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'hFFFC);
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h0003);
    wr(2'd2, 16'h2008);
    check("R8 stopped", mem_req, 0);
    rd(2'd0, v); check("R8 grant word counted", v, 16'hFFFE);
    rd(2'd1, v); check("R8 address", v, 16'h0004);
    rd(2'd2, v); check("R8 ctrl", v, 16'h2082);
  endtask

  task automatic t_fault();
    logic [15:0] v;
    wr(2'd2, 16'h0000);
    mem_err = 1'b1;
    wr(2'd0, 16'hFFFE);
    wr(2'd2, 16'h0003);
    wait_done("R9");
    mem_err = 1'b0;
    rd(2'd0, v); check("R9 count not advanced", v, 16'hFFFE);
    rd(2'd2, v); check("R9 error and done", v, 16'h8082);
    check("R9 request dropped", mem_req, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_mode();
    t_to_mem();
    t_from_mem();
    t_clear();
    t_carry();
    t_empty();
    t_abort();
    t_abort_grant();
    t_fault();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule